// File: doc/BRIEF.md
# Centralized Exception Control Unit

This unit sits beside a processor pipeline and owns the three registers that exception handling needs: a cause word, a saved-PC word and a status word. Each cycle it looks at one synchronous exception request from the pipeline and at a set of hardware interrupt lines. It accepts at most one event. Synchronous requests always win over interrupts. On acceptance it does four things in the same cycle. It records the cause code and the delay-slot flag. It saves the restart address. It pushes the status mode/enable stack. It drives a fetch redirect to one fixed handler address. The handler software reads the cause word to find out what happened.

The status word keeps an 8-bit interrupt mask and a three-level stack of kernel/user and interrupt-enable pairs. An accepted event shifts the stack up by one pair and clears the current pair, which gives kernel mode with interrupts disabled. A return-from-exception pulse shifts the stack back down by one pair. That pulse does not touch the program counter. Software jumps to the saved address on its own. The pipeline reads and writes the registers through a plain read port and write port that serve move-from and move-to coprocessor instructions. The redirect is a single-cycle control strobe with no back-pressure. The fetch stage must act on it in the cycle it is high.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, the status, cause and saved-PC registers all read zero, and no redirect is driven.
- R2: In any cycle where an event is accepted, `redirect_valid` is 1 in that same cycle and `redirect_pc` equals HANDLER_ADDR (default 0x80000080). In all other cycles `redirect_valid` is 0.
- R3: On acceptance, the saved PC becomes `ex_pc`. If `ex_in_delay` is 1, it becomes `ex_pc` minus 4 instead, which is the address of the branch. Cause bit 31 records `ex_in_delay`.
- R4: Cause bits 5:2 hold the code of the accepted event. A synchronous request stores `ex_code`, for example 4 for a load alignment error, 5 for a store alignment error and 12 for overflow. An interrupt stores 0. Cause bits 1:0 and 7:6 always read zero.
- R5: Cause bits 15:10 show the live `irq_lines` (line 0 at bit 10). Cause bits 9:8 are software pending bits, set by a cause write. A cause write changes no other cause bit.
- R6: On acceptance, status bits 5:0 become the old bits 3:0 followed by 00. Status bits 15:8 keep their value.
- R7: A return pulse in a cycle with no acceptance copies status bits 5:2 into bits 3:0 and leaves bits 5:4 unchanged. It never drives a redirect.
- R8: A synchronous request is accepted whenever it is present. It takes priority over any interrupt in the same cycle.
- R9: An interrupt is accepted only when status bit 0 (current enable) is 1 and at least one pending bit is set whose mask bit is also set. The pending bits are cause bits 15:8, and the mask bits are status bits 15:8 in the same positions.
- R10: Register select 12 is status, 13 is cause and 14 is the saved PC. Any other select reads zero. A status write keeps only bits 15:8 and 5:0.
- R11: In a cycle where an event is accepted, a return pulse and any register write are both dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Synchronous exception request |
| ex_code | input | 4 | Code of the synchronous exception |
| ex_pc | input | 32 | PC of the instruction being interrupted or faulting |
| ex_in_delay | input | 1 | That instruction sits in a branch delay slot |
| irq_lines | input | 6 | Hardware interrupt request levels |
| rfe | input | 1 | Return-from-exception pulse |
| rd_sel | input | 5 | Register number for the read port |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register number for the write port |
| wr_data | input | 32 | Write data |
| redirect_valid | output | 1 | Fetch must jump to redirect_pc this cycle |
| redirect_pc | output | 32 | Handler entry address |

## Verification
The bench builds the unit with its default parameters: six hardware lines, two software lines, a three-level stack and a 4-byte instruction step. With these values every mask and pending position can be reached from the status and cause words, so masked-off interrupts, software-raised interrupts and a stack that is already full can all be driven directly. The 4-byte step makes the delay-slot restart address an exact value the bench can check. The table of vectors mixes synchronous codes with interrupts under different masks and enable states. The directed tests then cover the return pop, write masking, unmapped selects and a cycle where acceptance, return and a write all arrive together.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN       = 32;
  localparam int CODE_W     = 4;
  localparam int SEL_W      = 5;
  localparam int NUM_HW     = 6;
  localparam int NUM_SW     = 2;
  localparam int LINES      = NUM_HW + NUM_SW;
  localparam int CODE_LSB   = 2;
  localparam int SW_LSB     = 8;
  localparam int HW_LSB     = SW_LSB + NUM_SW;
  localparam int MASK_LSB   = 8;
  localparam int BD_BIT     = 31;
  localparam int PAIR_W     = 2;

  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  typedef enum logic [CODE_W-1:0] {
    CODE_IRQ         = 4'd0,
    CODE_LOAD_ALIGN  = 4'd4,
    CODE_STORE_ALIGN = 4'd5,
    CODE_OVERFLOW    = 4'd12
  } exc_code_e;
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
#(
  parameter int N_LINES = LINES
) (
  input  logic                sync_req,
  input  logic [CODE_W-1:0]   sync_code,
  input  logic                int_enable,
  input  logic [N_LINES-1:0]  pending,
  input  logic [N_LINES-1:0]  mask,
  output logic                take,
  output logic [CODE_W-1:0]   take_code
);
  logic [N_LINES-1:0] hit;

  for (genvar i = 0; i < N_LINES; i++) begin : g_qual
    assign hit[i] = pending[i] & mask[i];
  end

  logic take_irq;
  assign take_irq = int_enable & (|hit);

  always_comb begin
    take      = sync_req | take_irq;
    take_code = sync_req ? sync_code : CODE_IRQ;
  end
endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int MASK_W = LINES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] status
);
  localparam int STACK_W = LEVELS * PAIR_W;

  logic [MASK_W-1:0]  mask_q;
  logic [PAIR_W-1:0]  pair_q [LEVELS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (!push && !pop && wr_en) begin
      mask_q <= wr_data[MASK_LSB +: MASK_W];
    end
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_level
    logic [PAIR_W-1:0] below;
    logic [PAIR_W-1:0] above;
    if (i == 0) begin : g_bot
      assign below = '0;
    end else begin : g_mid
      assign below = pair_q[i-1];
    end
    if (i == LEVELS - 1) begin : g_top
      assign above = pair_q[i];
    end else begin : g_low
      assign above = pair_q[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pair_q[i] <= '0;
      end else if (push) begin
        pair_q[i] <= below;
      end else if (pop) begin
        pair_q[i] <= above;
      end else if (wr_en) begin
        pair_q[i] <= wr_data[i*PAIR_W +: PAIR_W];
      end
    end
  end

  always_comb begin
    status = '0;
    status[MASK_LSB +: MASK_W] = mask_q;
    for (int i = 0; i < LEVELS; i++) begin
      status[i*PAIR_W +: PAIR_W] = pair_q[i];
    end
  end
endmodule

// File: rtl/exc_cause_epc.sv
module exc_cause_epc
  import exc_pkg::*;
#(
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] take_code,
  input  logic              in_delay,
  input  logic [XLEN-1:0]   pc,
  input  logic [NUM_HW-1:0] hw_lines,
  input  logic              wr_cause,
  input  logic              wr_epc,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   cause,
  output logic [XLEN-1:0]   epc
);
  logic [CODE_W-1:0] code_q;
  logic              bd_q;
  logic [NUM_SW-1:0] sw_q;
  logic [XLEN-1:0]   epc_q;
  logic [XLEN-1:0]   restart_pc;

  assign restart_pc = in_delay ? (pc - XLEN'(INSN_BYTES)) : pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      bd_q   <= 1'b0;
      epc_q  <= '0;
      sw_q   <= '0;
    end else if (take) begin
      code_q <= take_code;
      bd_q   <= in_delay;
      epc_q  <= restart_pc;
    end else begin
      if (wr_cause) sw_q  <= wr_data[SW_LSB +: NUM_SW];
      if (wr_epc)   epc_q <= wr_data;
    end
  end

  always_comb begin
    cause = '0;
    cause[BD_BIT]                = bd_q;
    cause[HW_LSB +: NUM_HW]      = hw_lines;
    cause[SW_LSB +: NUM_SW]      = sw_q;
    cause[CODE_LSB +: CODE_W]    = code_q;
  end

  assign epc = epc_q;
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] HANDLER_ADDR = 32'h8000_0080,
  parameter int          LEVELS       = 3,
  parameter int          INSN_BYTES   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ex_valid,
  input  logic [3:0]  ex_code,
  input  logic [31:0] ex_pc,
  input  logic        ex_in_delay,
  input  logic [5:0]  irq_lines,
  input  logic        rfe,
  input  logic [4:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc
);
  logic [XLEN-1:0]   status_w;
  logic [XLEN-1:0]   cause_w;
  logic [XLEN-1:0]   epc_w;
  logic              take;
  logic [CODE_W-1:0] take_code;
  logic              pop;

  exc_select #(.N_LINES(LINES)) u_select (
    .sync_req   (ex_valid),
    .sync_code  (ex_code),
    .int_enable (status_w[0]),
    .pending    (cause_w[SW_LSB +: LINES]),
    .mask       (status_w[MASK_LSB +: LINES]),
    .take       (take),
    .take_code  (take_code)
  );

  assign pop = rfe & ~take;

  exc_status_stack #(.LEVELS(LEVELS), .MASK_W(LINES)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take),
    .pop     (pop),
    .wr_en   (wr_en && wr_sel == SEL_STATUS),
    .wr_data (wr_data),
    .status  (status_w)
  );

  exc_cause_epc #(.INSN_BYTES(INSN_BYTES)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_code (take_code),
    .in_delay  (ex_in_delay),
    .pc        (ex_pc),
    .hw_lines  (irq_lines),
    .wr_cause  (wr_en && wr_sel == SEL_CAUSE),
    .wr_epc    (wr_en && wr_sel == SEL_EPC),
    .wr_data   (wr_data),
    .cause     (cause_w),
    .epc       (epc_w)
  );

  always_comb begin
    case (rd_sel)
      SEL_STATUS: rd_data = status_w;
      SEL_CAUSE:  rd_data = cause_w;
      SEL_EPC:    rd_data = epc_w;
      default:    rd_data = '0;
    endcase
  end

  assign redirect_valid = take;
  assign redirect_pc    = HANDLER_ADDR;
endmodule

// File: rtl/exc_ctrl_unit_chk.sv
module exc_ctrl_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        taken,
  input logic        sync_req,
  input logic [3:0]  sync_code,
  input logic [31:0] pc,
  input logic        bd,
  input logic        rfe,
  input logic [31:0] status,
  input logic [31:0] cause,
  input logic [31:0] epc
);
  assert_epc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> epc == ($past(bd) ? $past(pc) - 32'd4 : $past(pc)));

  assert_entry_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (status[5:0] == {$past(status[3:0]), 2'b00}) && $stable(status[15:8]));

  assert_return_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !taken) |=> (status[3:0] == $past(status[5:2])) && $stable(status[5:4]));

  assert_sync_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> cause[5:2] == $past(sync_code));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !sync_req) |-> status[0]);
endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .taken     (redirect_valid),
  .sync_req  (ex_valid),
  .sync_code (ex_code),
  .pc        (ex_pc),
  .bd        (ex_in_delay),
  .rfe       (rfe),
  .status    (status_w),
  .cause     (cause_w),
  .epc       (epc_w)
);

// File: tb/exc_ctrl_unit_tb_top.sv
module exc_ctrl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_valid = 1'b0;
  logic [3:0]  ex_code = '0;
  logic [31:0] ex_pc = '0;
  logic        ex_in_delay = 1'b0;
  logic [5:0]  irq_lines = '0;
  logic        rfe = 1'b0;
  logic [4:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_ctrl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_code(ex_code),
    .ex_pc(ex_pc), .ex_in_delay(ex_in_delay), .irq_lines(irq_lines),
    .rfe(rfe), .rd_sel(rd_sel), .rd_data(rd_data), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  typedef struct packed {
    logic [15:0] st;
    logic        sync;
    logic [3:0]  code;
    logic [5:0]  irq;
    logic        bd;
    logic [31:0] pc;
    logic        take;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TABLE [NV] = '{
    '{16'hFF01, 1'b1, 4'd12, 6'b000000, 1'b0, 32'h0040_0010, 1'b1},
    '{16'h0405, 1'b0, 4'd0,  6'b000001, 1'b0, 32'h0040_0020, 1'b1},
    '{16'hFF00, 1'b0, 4'd0,  6'b000001, 1'b0, 32'h0040_0030, 1'b0},
    '{16'h0201, 1'b0, 4'd0,  6'b000001, 1'b0, 32'h0040_0040, 1'b0},
    '{16'hFF0D, 1'b1, 4'd4,  6'b100000, 1'b1, 32'h0040_0100, 1'b1},
    '{16'hFF01, 1'b1, 4'd5,  6'b000000, 1'b0, 32'h0040_0200, 1'b1},
    '{16'hFF3F, 1'b1, 4'd4,  6'b000000, 1'b0, 32'h0040_0300, 1'b1},
    '{16'h2001, 1'b0, 4'd0,  6'b001000, 1'b1, 32'h0040_0400, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [4:0] sel, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(logic [4:0] sel, output logic [31:0] data);
    rd_sel = sel;
    #1;
    data = rd_data;
  endtask

  logic [31:0] prev_epc;
  logic [31:0] val;
  logic [31:0] exp_st;
  logic        last_bd;
  logic [3:0]  last_code;

  initial begin
    prev_epc = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    read_reg(5'd12, val); check("R1 status", val, 32'h0);
    read_reg(5'd13, val); check("R1 cause", val, 32'h0);
    read_reg(5'd14, val); check("R1 epc", val, 32'h0);
    check("R1 redirect", {31'b0, redirect_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg(5'd12, val); check("R1 status after release", val, 32'h0);

    for (int v = 0; v < NV; v++) begin
      irq_lines = '0;
      write_reg(5'd13, 32'h0);
      write_reg(5'd12, {16'h0, TABLE[v].st});
      // event cycle (write_reg leaves us just after a negedge)
      ex_valid = TABLE[v].sync; ex_code = TABLE[v].code;
      irq_lines = TABLE[v].irq; ex_in_delay = TABLE[v].bd; ex_pc = TABLE[v].pc;
      #1;
      // R2 R8 R9: acceptance decision and handler address
      check($sformatf("R2/R9 take v%0d", v), {31'b0, redirect_valid}, {31'b0, TABLE[v].take});
      if (TABLE[v].take) check($sformatf("R2 target v%0d", v), redirect_pc, 32'h8000_0080);
      @(negedge clk);
      ex_valid = 1'b0;
      if (TABLE[v].take) begin
        exp_st = {16'h0, TABLE[v].st & 16'hFF00} | {16'h0, (TABLE[v].st << 2) & 16'h003C};
        prev_epc = TABLE[v].bd ? TABLE[v].pc - 32'd4 : TABLE[v].pc;
        last_bd = TABLE[v].bd;
        last_code = TABLE[v].sync ? TABLE[v].code : 4'd0;
        read_reg(5'd13, val);
        // R4 R5 R8 R3: code, live lines, delay flag
        check($sformatf("R4/R8 cause v%0d", v), val,
              ({31'b0, last_bd} << 31) | ({26'b0, TABLE[v].irq} << 10) | ({28'b0, last_code} << 2));
      end else begin
        exp_st = {16'h0, TABLE[v].st};
      end
      read_reg(5'd12, val); check($sformatf("R6 status v%0d", v), val, exp_st);
      read_reg(5'd14, val); check($sformatf("R3 epc v%0d", v), val, prev_epc);
    end

    irq_lines = '0;
    ex_in_delay = 1'b0;
    // R5: cause write affects only software pending bits
    write_reg(5'd12, 32'h0);
    write_reg(5'd13, 32'hFFFF_FFFF);
    read_reg(5'd13, val);
    check("R5 cause write mask", val, ({31'b0, last_bd} << 31) | 32'h300 | ({28'b0, last_code} << 2));
    write_reg(5'd13, 32'h0);

    // R10: status write masking and unmapped select
    write_reg(5'd12, 32'hFFFF_FFFF);
    read_reg(5'd12, val); check("R10 status write mask", val, 32'h0000_FF3F);
    read_reg(5'd5, val);  check("R10 unmapped read", val, 32'h0);

    // R7: return pops the stack and drives no redirect
    write_reg(5'd12, 32'h0000_0034);
    rfe = 1'b1;
    #1;
    check("R7 no redirect", {31'b0, redirect_valid}, 32'h0);
    @(negedge clk);
    rfe = 1'b0;
    read_reg(5'd12, val); check("R7 pop", val, 32'h0000_003D);

    // R9 R5: software pending bit raises an interrupt
    write_reg(5'd12, 32'h0000_0101);
    ex_pc = 32'h0040_0500;
    write_reg(5'd13, 32'h0000_0100);
    // the write landed at the last posedge; request is now visible
    #1;
    check("R9 software interrupt taken", {31'b0, redirect_valid}, 32'h1);
    @(negedge clk);
    read_reg(5'd13, val); check("R4 software interrupt cause", val, 32'h0000_0100);
    read_reg(5'd12, val); check("R6 software interrupt status", val, 32'h0000_0104);
    read_reg(5'd14, val); check("R3 software interrupt epc", val, 32'h0040_0500);
    write_reg(5'd13, 32'h0);

    // R11: acceptance beats return and register write in the same cycle
    write_reg(5'd12, 32'h0000_0001);
    ex_valid = 1'b1; ex_code = 4'd12; ex_pc = 32'h0040_0600;
    rfe = 1'b1; wr_en = 1'b1; wr_sel = 5'd12; wr_data = 32'h0000_AB3F;
    @(negedge clk);
    ex_valid = 1'b0; rfe = 1'b0; wr_en = 1'b0;
    read_reg(5'd12, val); check("R11 status", val, 32'h0000_0004);
    read_reg(5'd14, val); check("R11 epc", val, 32'h0040_0600);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule